// File: doc/BRIEF.md
# Interrupt Request and Vector Sequencer

This block sits next to a small 8-bit processor core. It decides which of three interrupt sources the core takes and when it takes it. The three sources are a reset request, a software-interrupt instruction and an external interrupt pin. For the source it picks, it supplies the 16-bit address of the vector word. The core reads the handler's high byte at that even address and the low byte at the next odd address. Stacking, the return from an interrupt and the datapath belong to the core.

The external pin goes through a synchroniser. Its falling edges are captured in a pending flag, but only while the pin's enable input is set. The pin's synchronised level is also given to the core for its branch-on-pin instructions. Requests are evaluated only at instruction boundaries, with one exception: a reset request is taken in the next cycle from any state. When the block takes an interrupt, it pulses a command that sets the core's interrupt mask. This blocks any nested hardware interrupt until software clears the mask.

Top module: `irq_vector_seq`

## Requirements
- R1: A reset request (`rst_req_n` low or `int_rst` high) is taken in the next cycle, whatever the boundary strobe or the mask. The block pulses `take_int` and `set_mask`, sets `vec_addr` to 0x1FFE, and clears every pending request.
- R2: A software interrupt (`swi_exec` pulse) is taken at the next instruction boundary even while `cpu_mask` is 1, with `vec_addr` = 0x1FFC.
- R3: A pending external interrupt with `cpu_mask` = 0 is taken at an instruction boundary with `vec_addr` = 0x1FFA, and its pending flag is then cleared.
- R4: While `cpu_mask` is 1, a pending external interrupt is not taken but stays pending. It is taken at the first boundary after the mask clears.
- R5: When an external interrupt is pending and unmasked at the same time as a software interrupt, the external one is taken first. The software interrupt stays pending and is taken at a later boundary.
- R6: Only a falling edge of `irq_pin` marks an external interrupt pending, and only while `irq_en` is 1. A rising edge, or a falling edge while `irq_en` is 0, leaves nothing pending.
- R7: Apart from a reset request, no interrupt is taken in a cycle after which `insn_bound` was low.
- R8: `take_int` and `set_mask` are one-cycle pulses in the cycle after a decision. `vec_addr` changes only together with a `take_int` pulse and otherwise holds its value.
- R9: `pin_level` follows `irq_pin` two clock edges later.
- R10: After `rst`, `take_int` and `set_mask` are 0, `vec_addr` is 0x1FFE, `pin_level` is 1 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_req_n | input | 1 | Reset request from the reset pin, active low |
| int_rst | input | 1 | Reset request from an internal source, active high |
| swi_exec | input | 1 | One-cycle pulse when a software-interrupt instruction executes |
| irq_pin | input | 1 | External interrupt pin, asynchronous |
| irq_en | input | 1 | Allows falling edges of the pin to be captured |
| cpu_mask | input | 1 | Core interrupt-mask bit; 1 blocks the external interrupt |
| insn_bound | input | 1 | High in the cycle an instruction completes |
| take_int | output | 1 | One-cycle pulse: the core must enter the interrupt sequence |
| vec_addr | output | 16 | Even address of the selected vector word |
| set_mask | output | 1 | One-cycle command to set the core's mask bit |
| pin_level | output | 1 | Synchronised level of the pin |

## Verification
The bench builds the block with its default parameters: a 16-bit address, the vector table at the top of an 8 KB space (0x1FFF) and a two-stage synchroniser. These values put all three vector addresses and the two-edge latency of the pin level within reach of the checks. Together with a short edge-to-pending delay, this lets every combination of mask, enable, software request and pin edge settle within a few cycles. The combinations include the ordering case where the external request beats a software request and the software request is taken afterwards.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  // Source code n selects the vector word at VEC_TOP - (2n + 1).
  typedef enum logic [1:0] {
    SRC_RESET = 2'd0,
    SRC_SWI   = 2'd1,
    SRC_EXT   = 2'd2,
    SRC_NONE  = 2'd3
  } src_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign fall  = prev & ~chain[STAGES-1];
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_seq_pkg::*;
(
  input  logic reset_hit,
  input  logic boundary,
  input  logic ext_pend,
  input  logic mask,
  input  logic swi_req,
  output logic fire,
  output src_e src
);
  always_comb begin
    fire = 1'b1;
    if (reset_hit)                       src = SRC_RESET;
    else if (boundary && ext_pend && !mask) src = SRC_EXT;
    else if (boundary && swi_req)        src = SRC_SWI;
    else begin
      src  = SRC_NONE;
      fire = 1'b0;
    end
  end
endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq
  import irq_seq_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] VEC_TOP   = 16'h1FFF,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_req_n,
  input  logic              int_rst,
  input  logic              swi_exec,
  input  logic              irq_pin,
  input  logic              irq_en,
  input  logic              cpu_mask,
  input  logic              insn_bound,
  output logic              take_int,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              set_mask,
  output logic              pin_level
);
  localparam logic [ADDR_W-1:0] VEC_RST = VEC_TOP - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] VEC_EXT = VEC_TOP - ADDR_W'(5);

  function automatic logic [ADDR_W-1:0] vec_of(input src_e s);
    return VEC_TOP - {{(ADDR_W-3){1'b0}}, s, 1'b1};
  endfunction

  logic reset_hit, fall, swi_req, fire;
  logic ext_pend_q, swi_pend_q, take_q;
  logic [ADDR_W-1:0] vec_q;
  src_e src;

  assign reset_hit = !rst_req_n || int_rst;
  assign swi_req   = swi_pend_q || swi_exec;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(irq_pin), .level(pin_level), .fall(fall)
  );

  irq_arbiter u_arb (
    .reset_hit(reset_hit), .boundary(insn_bound), .ext_pend(ext_pend_q),
    .mask(cpu_mask), .swi_req(swi_req), .fire(fire), .src(src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_pend_q <= 1'b0;
      swi_pend_q <= 1'b0;
      take_q     <= 1'b0;
      vec_q      <= VEC_RST;
    end else begin
      take_q <= fire;
      if (fire) vec_q <= vec_of(src);
      if (reset_hit) begin
        ext_pend_q <= 1'b0;
        swi_pend_q <= 1'b0;
      end else begin
        ext_pend_q <= (ext_pend_q && !(fire && src == SRC_EXT)) || (fall && irq_en);
        swi_pend_q <= swi_req && !(fire && src == SRC_SWI);
      end
    end
  end

  assign take_int = take_q;
  assign set_mask = take_q;
  assign vec_addr = vec_q;

  p_reset_taken_r1: assert property (@(posedge clk) disable iff (rst)
    $past(reset_hit && !rst) |-> (take_int && vec_addr == VEC_RST));
  p_ext_masked_r4: assert property (@(posedge clk) disable iff (rst)
    (take_int && vec_addr == VEC_EXT && !$past(reset_hit)) |-> !$past(cpu_mask));
  p_boundary_only_r7: assert property (@(posedge clk) disable iff (rst)
    take_int |-> ($past(insn_bound) || $past(reset_hit)));
  p_vec_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !take_int |-> $stable(vec_addr));
endmodule

// File: tb/irq_vector_seq_bench.sv
module irq_vector_seq_bench;
  logic clk = 0, rst = 1, rst_req_n = 1, int_rst = 0, swi_exec = 0;
  logic irq_pin = 1, irq_en = 0, cpu_mask = 0, insn_bound = 0;
  logic take_int, set_mask, pin_level;
  logic [15:0] vec_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_vector_seq u_irq_vector_seq (
    .clk(clk), .rst(rst), .rst_req_n(rst_req_n), .int_rst(int_rst),
    .swi_exec(swi_exec), .irq_pin(irq_pin), .irq_en(irq_en),
    .cpu_mask(cpu_mask), .insn_bound(insn_bound), .take_int(take_int),
    .vec_addr(vec_addr), .set_mask(set_mask), .pin_level(pin_level)
  );

  // {mask, en, swi, fall, exp_take, pad[0], exp_vec[15:0]}
  localparam int NV = 8;
  localparam logic [21:0] VECS [NV] = '{
    {5'b01011, 1'b0, 16'h1FFA},  // R3 unmasked edge
    {5'b11010, 1'b0, 16'h1FFE},  // R4 masked edge
    {5'b10101, 1'b0, 16'h1FFC},  // R2 swi under mask
    {5'b00101, 1'b0, 16'h1FFC},  // R2 swi unmasked
    {5'b00010, 1'b0, 16'h1FFE},  // R6 edge while disabled
    {5'b01111, 1'b0, 16'h1FFA},  // R5 ext beats swi
    {5'b11111, 1'b0, 16'h1FFC},  // R4 mask lets swi through
    {5'b01000, 1'b0, 16'h1FFE}   // R7 nothing requested
  };

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic boundary();
    insn_bound = 1; cyc(1); insn_bound = 0;
  endtask

  task automatic reset_req();
    rst_req_n = 0; cyc(1); rst_req_n = 1; cyc(1);
  endtask

  task automatic pin_fall();
    irq_pin = 0; cyc(4); irq_pin = 1; cyc(4);
  endtask

  initial begin
    #40000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog got hang exp finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3); rst = 0; cyc(1);
    chk("R10 take", {15'd0, take_int}, 16'd0);
    chk("R10 mask", {15'd0, set_mask}, 16'd0);
    chk("R10 vec", vec_addr, 16'h1FFE);
    chk("R10 level", {15'd0, pin_level}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      reset_req();
      cpu_mask = VECS[i][21]; irq_en = VECS[i][20];
      if (VECS[i][18]) pin_fall();
      if (VECS[i][19]) begin swi_exec = 1; cyc(1); swi_exec = 0; end
      cyc(1);
      boundary();
      chk($sformatf("R%0d take v%0d", (i == 4) ? 6 : 3, i), {15'd0, take_int}, {15'd0, VECS[i][17]});
      chk($sformatf("R2/R3 vec v%0d", i), vec_addr, VECS[i][15:0]);
      if (i == 5) begin
        cyc(1); cpu_mask = 1; boundary();
        chk("R5 swi after ext", vec_addr, 16'h1FFC);
      end
      cpu_mask = 0; irq_en = 0;
    end

    // R1 from pin request and internal source, irrespective of boundary
    cyc(2); cpu_mask = 1; swi_exec = 1; cyc(1); swi_exec = 0; boundary(); cyc(1);
    rst_req_n = 0; cyc(1); rst_req_n = 1;
    chk("R1 take", {14'd0, take_int, set_mask}, 16'd3);
    chk("R1 vec", vec_addr, 16'h1FFE);
    cyc(1);
    chk("R8 pulse ends", {14'd0, take_int, set_mask}, 16'd0);
    int_rst = 1; cyc(1); int_rst = 0;
    chk("R1 internal", {15'd0, take_int}, 16'd1);

    // R1 clears pending edge
    cpu_mask = 0; irq_en = 1; pin_fall(); reset_req(); boundary();
    chk("R1 clears pending", {15'd0, take_int}, 16'd0);

    // R7 no boundary, then R4 masked stays pending until cleared
    cpu_mask = 1; pin_fall(); cyc(3);
    chk("R7 no boundary", {15'd0, take_int}, 16'd0);
    boundary();
    chk("R4 masked", {15'd0, take_int}, 16'd0);
    cpu_mask = 0; boundary();
    chk("R4 later taken", vec_addr, 16'h1FFA);
    chk("R8 set_mask", {15'd0, set_mask}, 16'd1);
    cyc(2);
    chk("R8 vec holds", vec_addr, 16'h1FFA);

    // R6 rising edge only
    reset_req(); irq_pin = 0; irq_en = 0; cyc(5); irq_en = 1; irq_pin = 1; cyc(5);
    boundary();
    chk("R6 rising", {15'd0, take_int}, 16'd0);

    // R9 level latency
    irq_pin = 0; cyc(1);
    chk("R9 one edge", {15'd0, pin_level}, 16'd1);
    cyc(1);
    chk("R9 two edges", {15'd0, pin_level}, 16'd0);
    irq_pin = 1; irq_en = 0; cyc(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule